// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block sits in front of a small shared word array and serves several processor ports at once. Each port can read a word while placing a reservation on it (load-reserved), try to write a word only if that reservation is still intact (store-conditional), or write a word unconditionally (plain store). Software uses the pair to build atomic read-modify-write sequences, such as claiming a queue slot or taking a lock. The sequence is retried whenever the conditional store reports failure.

Every port holds one reservation, made of a valid flag and a word address. Any completed write to an address cancels the other ports' reservations on that address, so that only one competing conditional store can win. Requests that arrive in the same cycle are handled as if they ran one after another, lowest port number first. Each accepted request gets exactly one response in the following cycle.

Top module: `lrsc_monitor`

## Requirements
- R1: While reset is asserted and after it is released, no response is raised and no port holds a reservation. Every memory word reads as zero until it is written.
- R2: Operation code 2'b00 (load-reserved) returns the word at the request address on rsp_rdata. It also sets the port's reservation to that address.
- R3: Operation code 2'b01 (store-conditional) succeeds when the port holds a valid reservation whose address equals the request address. A successful one writes req_wdata to that word and returns rsp_fail = 0.
- R4: A store-conditional without a matching valid reservation leaves memory unchanged and returns rsp_fail = 1.
- R5: A successful store-conditional cancels the reservation of every other port that is reserved on the same address.
- R6: Operation code 2'b10 (plain store) always writes and returns rsp_fail = 0. It cancels every port's reservation on that address, including the issuer's.
- R7: After any store-conditional, successful or not, the issuing port holds no reservation.
- R8: Requests in the same cycle take effect in ascending port order. When two ports try a store-conditional on the same address in one cycle, the lower port can succeed and the higher port then fails. A load-reserved sees the data written by lower ports in the same cycle.
- R9: Operation code 2'b11 is idle. It produces no response and does not change memory or any reservation.
- R10: A request with req_valid = 1 and a non-idle code gets rsp_valid = 1 on the clock edge after the edge that accepts it, for that single cycle. rsp_rdata is 0 except on load-reserved, and rsp_fail is 0 except on a failed store-conditional.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORT | Request strobe, one bit per port |
| req_op | input | 2*NPORT | Operation code per port (2 bits each, port p at bits 2p+1:2p) |
| req_addr | input | NPORT*AW | Word address per port |
| req_wdata | input | NPORT*DW | Write data per port |
| rsp_valid | output | NPORT | Response strobe per port |
| rsp_rdata | output | NPORT*DW | Read data per port (load-reserved only) |
| rsp_fail | output | NPORT | 1 = store-conditional failed, 0 otherwise |

## Verification
Every result is due exactly one clock edge after the edge that takes the request: the response strobe, the read data and the status. A reservation change made by a request shows up in the status of any later store-conditional, and a memory write shows up in any later load-reserved. The bench drives inputs on the falling edge and computes the expected responses with its own serial model before the rising edge. It compares them on the next falling edge, so each check samples the single cycle in which that response is valid. Reservation and memory side effects are checked through later requests on the ports, never by reading internal state.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  typedef enum logic [1:0] {
    OP_LR   = 2'b00,
    OP_SC   = 2'b01,
    OP_ST   = 2'b10,
    OP_IDLE = 2'b11
  } lrsc_op_e;

  // true when a reservation is live and names the target word
  function automatic logic resv_hit(input logic held_v, input logic [31:0] held_a,
                                    input logic [31:0] tgt_a);
    return held_v && (held_a == tgt_a);
  endfunction

  // a request counts only when strobed with a non-idle code
  function automatic logic req_live(input logic v, input logic [1:0] op);
    return v && (op != OP_IDLE);
  endfunction

endpackage

// File: rtl/lrsc_mem.sv
module lrsc_mem #(
  parameter int AW = 4,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DEPTH*DW-1:0] mem_nxt,
  output logic [DEPTH*DW-1:0] mem_cur
);

  for (genvar d = 0; d < DEPTH; d++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) mem_cur[d*DW +: DW] <= '0;
      else        mem_cur[d*DW +: DW] <= mem_nxt[d*DW +: DW];
    end
  end

endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int NPORT = 4,
  parameter int AW    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    v_nxt,
  input  logic [NPORT*AW-1:0] a_nxt,
  output logic [NPORT-1:0]    v_cur,
  output logic [NPORT*AW-1:0] a_cur
);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_cur[p]            <= 1'b0;
        a_cur[p*AW +: AW]   <= '0;
      end else begin
        v_cur[p]            <= v_nxt[p];
        a_cur[p*AW +: AW]   <= a_nxt[p*AW +: AW];
      end
    end
  end

endmodule

// File: rtl/lrsc_serial.sv
module lrsc_serial
  import lrsc_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int AW    = 4,
  parameter int DW    = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic [NPORT-1:0]    req_valid,
  input  logic [2*NPORT-1:0]  req_op,
  input  logic [NPORT*AW-1:0] req_addr,
  input  logic [NPORT*DW-1:0] req_wdata,
  input  logic [DEPTH*DW-1:0] mem_cur,
  input  logic [NPORT-1:0]    rv_cur,
  input  logic [NPORT*AW-1:0] ra_cur,
  output logic [DEPTH*DW-1:0] mem_nxt,
  output logic [NPORT-1:0]    rv_nxt,
  output logic [NPORT*AW-1:0] ra_nxt,
  output logic [NPORT-1:0]    act,
  output logic [NPORT*DW-1:0] rdata,
  output logic [NPORT-1:0]    fail,
  output logic [NPORT-1:0]    sc_ok
);

  lrsc_op_e        op_p [NPORT];
  logic [AW-1:0]   ad_p [NPORT];
  logic [DW-1:0]   wd_p [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_dec
    assign op_p[p] = lrsc_op_e'(req_op[2*p +: 2]);
    assign ad_p[p] = req_addr[p*AW +: AW];
    assign wd_p[p] = req_wdata[p*DW +: DW];
  end

  logic [DW-1:0]   m_w [DEPTH];
  logic [NPORT-1:0] v_w;
  logic [AW-1:0]   a_w [NPORT];

  // ports are walked in ascending order; each sees the effects of the ones before it
  always_comb begin
    for (int d = 0; d < DEPTH; d++) m_w[d] = mem_cur[d*DW +: DW];
    v_w = rv_cur;
    for (int p = 0; p < NPORT; p++) a_w[p] = ra_cur[p*AW +: AW];
    act   = '0;
    rdata = '0;
    fail  = '0;
    sc_ok = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (req_live(req_valid[p], op_p[p])) begin
        act[p] = 1'b1;
        case (op_p[p])
          OP_LR: begin
            rdata[p*DW +: DW] = m_w[ad_p[p]];
            v_w[p] = 1'b1;
            a_w[p] = ad_p[p];
          end
          OP_SC: begin
            if (resv_hit(v_w[p], 32'(a_w[p]), 32'(ad_p[p]))) begin
              m_w[ad_p[p]] = wd_p[p];
              sc_ok[p] = 1'b1;
              for (int q = 0; q < NPORT; q++)
                if (q != p && resv_hit(v_w[q], 32'(a_w[q]), 32'(ad_p[p]))) v_w[q] = 1'b0;
            end else begin
              fail[p] = 1'b1;
            end
            v_w[p] = 1'b0;
          end
          OP_ST: begin
            m_w[ad_p[p]] = wd_p[p];
            for (int q = 0; q < NPORT; q++)
              if (resv_hit(v_w[q], 32'(a_w[q]), 32'(ad_p[p]))) v_w[q] = 1'b0;
          end
          default: ;
        endcase
      end
    end
    for (int d = 0; d < DEPTH; d++) mem_nxt[d*DW +: DW] = m_w[d];
    rv_nxt = v_w;
    for (int p = 0; p < NPORT; p++) ra_nxt[p*AW +: AW] = a_w[p];
  end

endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int AW    = 4,
  parameter int DW    = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    req_valid,
  input  logic [2*NPORT-1:0]  req_op,
  input  logic [NPORT*AW-1:0] req_addr,
  input  logic [NPORT*DW-1:0] req_wdata,
  output logic [NPORT-1:0]    rsp_valid,
  output logic [NPORT*DW-1:0] rsp_rdata,
  output logic [NPORT-1:0]    rsp_fail
);

  logic [DEPTH*DW-1:0] mem_cur, mem_nxt;
  logic [NPORT-1:0]    rv_cur, rv_nxt;
  logic [NPORT*AW-1:0] ra_cur, ra_nxt;
  logic [NPORT-1:0]    act, fail, sc_ok;
  logic [NPORT*DW-1:0] rdata;

  lrsc_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .rst_n(rst_n), .mem_nxt(mem_nxt), .mem_cur(mem_cur)
  );

  lrsc_resv #(.NPORT(NPORT), .AW(AW)) u_resv (
    .clk(clk), .rst_n(rst_n), .v_nxt(rv_nxt), .a_nxt(ra_nxt),
    .v_cur(rv_cur), .a_cur(ra_cur)
  );

  lrsc_serial #(.NPORT(NPORT), .AW(AW), .DW(DW)) u_serial (
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_cur(mem_cur), .rv_cur(rv_cur), .ra_cur(ra_cur),
    .mem_nxt(mem_nxt), .rv_nxt(rv_nxt), .ra_nxt(ra_nxt),
    .act(act), .rdata(rdata), .fail(fail), .sc_ok(sc_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_rdata <= '0;
      rsp_fail  <= '0;
    end else begin
      rsp_valid <= act;
      rsp_rdata <= rdata;
      rsp_fail  <= fail;
    end
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    // R10: a response only follows an accepted request
    a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[i] |-> $past(req_live(req_valid[i], req_op[2*i +: 2])));
    // R4: failure is reported only for a conditional store
    a_r4_fail_only_sc: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[i] && rsp_fail[i]) |-> $past(req_op[2*i +: 2] == OP_SC));
    // R3: a success needs the reservation held at the start of the cycle
    a_r3_success_needs_resv: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[i] && !rsp_fail[i] && $past(req_op[2*i +: 2] == OP_SC))
        |-> $past(rv_cur[i] && ra_cur[i*AW +: AW] == req_addr[i*AW +: AW]));
    // R7: the issuer's reservation is gone after its conditional store
    a_r7_own_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid[i] && req_op[2*i +: 2] == OP_SC) |-> !rv_cur[i]);
    for (genvar j = i + 1; j < NPORT; j++) begin : g_pair
      // R8: two ports never both win on one word in the same cycle
      a_r8_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
        !(sc_ok[i] && sc_ok[j] && req_addr[i*AW +: AW] == req_addr[j*AW +: AW]));
    end
  end

endmodule

// File: tb/test_lrsc_monitor.sv
module test_lrsc_monitor;
  localparam int NP = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0]    req_valid = '0;
  logic [2*NP-1:0]  req_op = '0;
  logic [NP*AW-1:0] req_addr = '0;
  logic [NP*DW-1:0] req_wdata = '0;
  logic [NP-1:0]    rsp_valid;
  logic [NP*DW-1:0] rsp_rdata;
  logic [NP-1:0]    rsp_fail;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [DW-1:0] mm [DEPTH];
  bit            mv [NP];
  logic [AW-1:0] ma [NP];
  bit            ev [NP];
  logic [DW-1:0] ed [NP];
  bit            ef [NP];
  string         et [NP];

  always #10 clk = ~clk;

  lrsc_monitor #(.NPORT(NP), .AW(AW), .DW(DW)) i_lrsc_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fail(rsp_fail)
  );

  function automatic void drop_resv(input logic [AW-1:0] a, input int skip);
    for (int q = 0; q < NP; q++)
      if (q != skip && mv[q] && ma[q] == a) mv[q] = 0;
  endfunction

  // expected outcome of the pending requests, port 0 first
  function automatic void model_apply();
    for (int p = 0; p < NP; p++) begin
      logic [1:0] op = req_op[2*p +: 2];
      logic [AW-1:0] a = req_addr[p*AW +: AW];
      logic [DW-1:0] w = req_wdata[p*DW +: DW];
      ev[p] = 0; ed[p] = '0; ef[p] = 0; et[p] = "R9";
      if (req_valid[p] && op != 2'b11) begin
        ev[p] = 1;
        if (op == 2'b00) begin
          ed[p] = mm[a]; mv[p] = 1; ma[p] = a; et[p] = "R2";
        end else if (op == 2'b01) begin
          if (mv[p] && ma[p] == a) begin
            mm[a] = w; drop_resv(a, p); et[p] = "R3";
          end else begin
            ef[p] = 1; et[p] = "R4";
          end
          mv[p] = 0;
        end else begin
          mm[a] = w; drop_resv(a, -1); et[p] = "R6";
        end
      end
    end
  endfunction

  task automatic put(input int p, input logic [1:0] op, input int a, input int w);
    req_valid[p] = 1'b1;
    req_op[2*p +: 2] = op;
    req_addr[p*AW +: AW] = AW'(a);
    req_wdata[p*DW +: DW] = DW'(w);
  endtask

  task automatic step(input string tag);
    model_apply();
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      string t = (tag != "") ? tag : et[p];
      checks++;
      if (rsp_valid[p] !== ev[p] || rsp_rdata[p*DW +: DW] !== ed[p] || rsp_fail[p] !== ef[p]) begin
        errors++;
        $display("FAIL %s port %0d: got v=%b d=%h f=%b expected v=%b d=%h f=%b", t, p,
                 rsp_valid[p], rsp_rdata[p*DW +: DW], rsp_fail[p], ev[p], ed[p], ef[p]);
      end
    end
    req_valid = '0;
    req_op = '1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int d = 0; d < DEPTH; d++) mm[d] = '0;
    for (int p = 0; p < NP; p++) begin mv[p] = 0; ma[p] = '0; end
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== '0) begin
      errors++; $display("FAIL R1 in reset: got %b expected 0", rsp_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rsp_valid !== '0) begin
      errors++; $display("FAIL R1 after reset: got %b expected 0", rsp_valid);
    end
    // R1: fresh memory reads zero; store-conditional with no reservation fails
    put(0, 2'b00, 0, 0); put(1, 2'b00, 1, 0); put(2, 2'b00, 2, 0); put(3, 2'b01, 3, 16'h5555);
    step("R1");
    // R3 then R7: success, then a repeat fails
    put(0, 2'b01, 0, 16'h1234); step("R3");
    put(0, 2'b01, 0, 16'h4321); step("R7");
    put(1, 2'b00, 0, 0); step("R3");
    // R5: winner cancels the other holder
    put(1, 2'b00, 5, 0); put(2, 2'b00, 5, 0); step("R2");
    put(1, 2'b01, 5, 16'hAAAA); step("R5");
    put(2, 2'b01, 5, 16'hBBBB); step("R5");
    // R8: same-cycle conditional stores, lower port wins; LR on a higher port sees the write
    put(0, 2'b00, 7, 0); put(3, 2'b00, 7, 0); step("R2");
    put(0, 2'b01, 7, 16'h0707); put(2, 2'b00, 7, 0); put(3, 2'b01, 7, 16'h7070); step("R8");
    // R6: plain store cancels a holder
    put(1, 2'b00, 9, 0); step("R2");
    put(2, 2'b10, 9, 16'h0909); step("R6");
    put(1, 2'b01, 9, 16'h9999); step("R6");
    // R9: idle code changes nothing
    put(0, 2'b00, 10, 0); step("R2");
    put(0, 2'b11, 10, 16'hDEAD); step("R9");
    put(0, 2'b01, 10, 16'h1010); step("R9");
    put(0, 2'b00, 10, 0); step("R9");
    // R10 and mixed traffic on a narrow address set
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < NP; p++)
        if ($urandom_range(0, 3) != 0)
          put(p, 2'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 65535)));
      step("");
      if ($urandom_range(0, 4) == 0) step("R10");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule